// File: doc/BRIEF.md
# SCSI Initiator Host Register Front-End

This block is the byte-wide register face of a simple SCSI initiator controller, as seen by a host processor. The host issues single-cycle byte reads and writes. Each access names a register through an address that the block shifts right by a fixed stride before decoding it. Behind that decoder sit a bank of sixteen read-side registers, a small byte FIFO, a status register and a level interrupt line. A read returns the value of the read-side register, and a write goes to the write-side meaning of the same index. The two sides coincide only for the configuration registers.

Commands are written to the command register. The block carries out FIFO flush, chip reset, bus reset, initiator command-complete and enable selection. NOP is accepted and does nothing. Any other code raises a sticky error flag. The interrupt line is the status register's pending bit brought out directly. Reading the interrupt register clears that bit, together with the two error bits.

The host interface has no back-pressure. Every strobe completes in the cycle it is presented. Read data is registered and appears on `host_rdata` in the cycle after `host_rd`. It holds there until the next read. When `host_rd` and `host_wr` are both high in one cycle, the write is performed and the read is ignored.

Top module: `scsi_regfront`

## Requirements
- R1: After reset, irq and cmd_err are 0, status (index 4) and interrupt (index 5) read 0x00, index 14 reads 0x04 (revision ID) and index 8 (configuration-1) reads 0x07.
- R2: The register index is host_addr shifted right by STRIDE, so address bits below the stride are ignored. An index of 16 or more is undecoded: writes to it change nothing and reads of it return 0x00.
- R3: Indices 8 and 11 to 15 read back the last value written. A write to any other index (except 2 and 3) leaves the value read at that index unchanged. Indices 0 and 1 always read 0x00.
- R4: Reading the interrupt register (index 5) returns its code and then clears status bits 7 (pending), 6 (gross error) and 5 (parity error), so irq is low in the next cycle.
- R5: A FIFO write (index 2) stores the byte when the count is below 15. When the count is 15 the byte is dropped, the count is unchanged and status bit 6 is set.
- R6: A FIFO read with a nonzero count pops one byte and sets status bit 7 (irq). The byte is returned when status bits [2:1] are nonzero, and 0x00 is returned otherwise. A read of an empty FIFO returns 0x00 and does not raise irq.
- R7: FIFO bytes are read back in write order. Draining the FIFO returns both pointers to zero, so later writes are read back correctly.
- R8: Command 0x11 (command-complete) replaces the FIFO contents with sense_byte then 0x00. It sets FIFO flags (index 7) to 0x02 and the interrupt register to 0x08 (function complete), ORs 0x07 (message-in phase) into status and raises irq.
- R9: Command 0x03 (bus reset) sets the interrupt register to 0x80. It raises irq only when configuration-1 bit 6 is 0.
- R10: Command 0x44 (enable selection) sets the interrupt register to 0x00 and leaves irq unchanged.
- R11: Command 0x01 (flush) empties the FIFO, sets the interrupt register to 0x08 and sets the sequence step (index 6) and FIFO flags (index 7) to 0x00. It does not raise irq.
- R12: Command 0x02 (chip reset) restores every register and the FIFO to their R1 values and drops irq. cmd_err is not cleared.
- R13: A command code (bits [6:0], bit 7 ignored) outside {0x00, 0x01, 0x02, 0x03, 0x11, 0x44} sets cmd_err, which stays set until rst_n. Such a code changes nothing else, and 0x00 has no effect at all.
- R14: irq equals status bit 7 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address, register index = host_addr >> STRIDE |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, data registered for the next cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data from the most recent read |
| sense_byte | input | 8 | Status byte loaded into the FIFO by command-complete |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| cmd_err | output | 1 | Sticky flag for an unrecognised command code |

## Verification
The hardest state to reach is a FIFO that is readable with real data. Out of reset the phase bits are zero, so every pop returns 0x00. Only command-complete ORs a phase into status. The stimulus therefore issues command-complete first, and then a flush that empties the FIFO but keeps the phase. Only after that does it fill the FIFO to its fifteen-byte limit, push one byte into overrun, and drain it to check order, the dropped byte and the pointer return. The bus-reset report-disable case is reached by rewriting configuration-1 between two bus-reset commands.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);

  // register indices the block's behaviour depends on
  localparam logic [IW-1:0] IX_CNT_LO = 4'd0;
  localparam logic [IW-1:0] IX_CNT_MD = 4'd1;
  localparam logic [IW-1:0] IX_FIFO   = 4'd2;
  localparam logic [IW-1:0] IX_CMD    = 4'd3;
  localparam logic [IW-1:0] IX_STAT   = 4'd4;
  localparam logic [IW-1:0] IX_INTR   = 4'd5;
  localparam logic [IW-1:0] IX_STEP   = 4'd6;
  localparam logic [IW-1:0] IX_FLAGS  = 4'd7;
  localparam logic [IW-1:0] IX_CFG1   = 4'd8;
  localparam logic [IW-1:0] IX_CFG2   = 4'd11;
  localparam logic [IW-1:0] IX_REV    = 4'd14;

  // status bits
  localparam int ST_PEND = 7;
  localparam int ST_GERR = 6;
  localparam int ST_PERR = 5;
  localparam logic [7:0] PH_MSG_IN = 8'h07;

  // interrupt codes
  localparam logic [7:0] IC_FUNC_DONE = 8'h08;
  localparam logic [7:0] IC_BUS_RST   = 8'h80;

  // command codes (bits [6:0])
  localparam logic [6:0] OP_NOP    = 7'h00;
  localparam logic [6:0] OP_FLUSH  = 7'h01;
  localparam logic [6:0] OP_CHIP   = 7'h02;
  localparam logic [6:0] OP_BUSRST = 7'h03;
  localparam logic [6:0] OP_DONE   = 7'h11;
  localparam logic [6:0] OP_SELEN  = 7'h44;

  typedef struct packed {
    logic nop;
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic done_seq;
    logic sel_en;
    logic unknown;
  } cmd_dec_t;

  function automatic logic is_readback(input logic [IW-1:0] ix);
    return (ix == IX_CFG1) || (ix >= IX_CFG2);
  endfunction
endpackage

// File: rtl/srf_addr_map.sv
module srf_addr_map #(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 2,
  parameter int NREG   = 16,
  localparam int IW    = $clog2(NREG),
  localparam int SW    = ADDR_W - STRIDE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IW-1:0]     idx,
  output logic              hit
);
  logic [SW-1:0] full_ix;
  assign full_ix = SW'(addr >> STRIDE);

  generate
    if (SW > IW) begin : g_wide
      assign idx = full_ix[IW-1:0];
      assign hit = (full_ix < SW'(NREG));
    end else begin : g_narrow
      assign idx = IW'(full_ix);
      assign hit = (32'(full_ix) < NREG);
    end
  endgenerate
endmodule

// File: rtl/srf_cmd_decode.sv
module srf_cmd_decode
  import srf_pkg::*;
(
  input  logic [6:0] code,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    unique case (code)
      OP_NOP:    dec.nop      = 1'b1;
      OP_FLUSH:  dec.flush    = 1'b1;
      OP_CHIP:   dec.chip_rst = 1'b1;
      OP_BUSRST: dec.bus_rst  = 1'b1;
      OP_DONE:   dec.done_seq = 1'b1;
      OP_SELEN:  dec.sel_en   = 1'b1;
      default:   dec.unknown  = 1'b1;
    endcase
  end
endmodule

// File: rtl/srf_fifo.sv
module srf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load2,
  input  logic [W-1:0]  ld0,
  input  logic [W-1:0]  ld1,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else if (load2) begin
      rp_q <= '0; wp_q <= PW'(2); cnt_q <= CW'(2);
    end else if (push) begin
      wp_q  <= step(wp_q);
      cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        rp_q <= '0; wp_q <= '0;
      end else begin
        rp_q <= step(rp_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load2) begin
      mem_q[0] <= ld0;
      mem_q[1] <= ld1;
    end else if (push && !clr) begin
      mem_q[wp_q] <= din;
    end
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import srf_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         STRIDE     = 2,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] REV_ID     = 8'h04,
  parameter logic [7:0] OWN_ID     = 8'h07,
  localparam int        CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        sense_byte,
  output logic              irq,
  output logic              cmd_err
);
  logic [IW-1:0] idx;
  logic          idx_ok;
  cmd_dec_t      dec;
  logic [7:0]    regs_q [NREG];
  logic [7:0]    rdata_q;
  logic          cmd_err_q;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic [7:0]    stat_q, intr_q;

  srf_addr_map #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .NREG(NREG)) u_map (
    .addr(host_addr), .idx(idx), .hit(idx_ok)
  );

  srf_cmd_decode u_dec (.code(host_wdata[6:0]), .dec(dec));

  // access qualification: a write wins over a simultaneous read
  logic wr_q, rd_q, wr_fifo, rd_fifo, wr_cmd;
  logic fifo_full, push, pop, overrun, fifo_clr, fifo_load, soft_rst;

  always_comb begin
    wr_q      = host_wr & idx_ok;
    rd_q      = host_rd & ~host_wr & idx_ok;
    wr_fifo   = wr_q & (idx == IX_FIFO);
    rd_fifo   = rd_q & (idx == IX_FIFO);
    wr_cmd    = wr_q & (idx == IX_CMD);
    fifo_full = (fifo_cnt == CW'(FIFO_DEPTH - 1));
    push      = wr_fifo & ~fifo_full;
    overrun   = wr_fifo & fifo_full;
    pop       = rd_fifo & (fifo_cnt != '0);
    soft_rst  = wr_cmd & dec.chip_rst;
    fifo_clr  = wr_cmd & (dec.flush | dec.chip_rst);
    fifo_load = wr_cmd & dec.done_seq;
  end

  srf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .load2(fifo_load),
    .ld0(sense_byte), .ld1(8'h00), .push(push), .din(host_wdata),
    .pop(pop), .head(fifo_head), .count(fifo_cnt)
  );

  function automatic logic [7:0] init_val(input int i);
    if (i == int'(IX_REV))  return REV_ID;
    if (i == int'(IX_CFG1)) return OWN_ID;
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= init_val(i);
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= init_val(i);
    end else begin
      if (wr_q && is_readback(idx)) regs_q[idx] <= host_wdata;
      if (overrun) regs_q[IX_STAT][ST_GERR] <= 1'b1;
      if (pop)     regs_q[IX_STAT][ST_PEND] <= 1'b1;
      if (rd_q && idx == IX_INTR) begin
        regs_q[IX_STAT][ST_PEND] <= 1'b0;
        regs_q[IX_STAT][ST_GERR] <= 1'b0;
        regs_q[IX_STAT][ST_PERR] <= 1'b0;
      end
      if (wr_cmd) begin
        if (dec.flush) begin
          regs_q[IX_INTR]  <= IC_FUNC_DONE;
          regs_q[IX_STEP]  <= 8'h00;
          regs_q[IX_FLAGS] <= 8'h00;
        end
        if (dec.bus_rst) begin
          regs_q[IX_INTR] <= IC_BUS_RST;
          if (!regs_q[IX_CFG1][6]) regs_q[IX_STAT][ST_PEND] <= 1'b1;
        end
        if (dec.done_seq) begin
          regs_q[IX_FLAGS] <= 8'h02;
          regs_q[IX_INTR]  <= IC_FUNC_DONE;
          regs_q[IX_STAT]  <= regs_q[IX_STAT] | PH_MSG_IN | 8'h80;
        end
        if (dec.sel_en) regs_q[IX_INTR] <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cmd_err_q <= 1'b0;
    else if (wr_cmd && dec.unknown) cmd_err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (host_rd && !host_wr) begin
      if (!idx_ok)
        rdata_q <= 8'h00;
      else if (idx == IX_FIFO)
        rdata_q <= (fifo_cnt != '0 && regs_q[IX_STAT][2:1] != 2'b00) ? fifo_head : 8'h00;
      else
        rdata_q <= regs_q[idx];
    end
  end

  assign stat_q     = regs_q[IX_STAT];
  assign intr_q     = regs_q[IX_INTR];
  assign irq        = stat_q[ST_PEND];
  assign cmd_err    = cmd_err_q;
  assign host_rdata = rdata_q;
endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [7:0]    host_wdata,
  input logic [3:0]    idx,
  input logic          idx_ok,
  input logic [CW-1:0] fifo_cnt,
  input logic [7:0]    stat_q,
  input logic [7:0]    intr_q,
  input logic          irq,
  input logic          cmd_err
);
  logic rd_only;
  assign rd_only = host_rd & ~host_wr & idx_ok;

  p_intr_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && idx == 4'd5 |=> !irq && !stat_q[6] && !stat_q[5]);

  p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(FIFO_DEPTH - 1));

  p_overrun_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && idx_ok && idx == 4'd2 && fifo_cnt == CW'(FIFO_DEPTH - 1)
    |=> $stable(fifo_cnt) && stat_q[6]);

  p_pop_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && idx == 4'd2 && fifo_cnt != '0
    |=> irq && fifo_cnt == $past(fifo_cnt) - 1'b1);

  p_done_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && idx_ok && idx == 4'd3 && host_wdata[6:0] == 7'h11
    |=> fifo_cnt == CW'(2) && irq && stat_q[2:0] == 3'd7 && intr_q == 8'h08);

  p_busrst_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && idx_ok && idx == 4'd3 && host_wdata[6:0] == 7'h03 |=> intr_q == 8'h80);

  p_cmd_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
endmodule

bind scsi_regfront scsi_regfront_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .idx(idx), .idx_ok(idx_ok), .fifo_cnt(fifo_cnt),
  .stat_q(stat_q), .intr_q(intr_q), .irq(irq), .cmd_err(cmd_err)
);

// File: tb/scsi_regfront_test.sv
module scsi_regfront_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int STRIDE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [7:0] sense_byte = 8'h02;
  logic irq, cmd_err;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regfront #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sense_byte(sense_byte), .irq(irq), .cmd_err(cmd_err)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] ix;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  // R3 read-back table, with R4 on the interrupt register
  localparam int NV = 18;
  localparam vec_t VTAB [NV] = '{
    '{1'b1, 4'd11, 8'hA5, 4'd3}, '{1'b0, 4'd11, 8'hA5, 4'd3},
    '{1'b1, 4'd12, 8'h3C, 4'd3}, '{1'b0, 4'd12, 8'h3C, 4'd3},
    '{1'b1, 4'd15, 8'h99, 4'd3}, '{1'b0, 4'd15, 8'h99, 4'd3},
    '{1'b1, 4'd14, 8'h5E, 4'd3}, '{1'b0, 4'd14, 8'h5E, 4'd3},
    '{1'b1, 4'd0,  8'h12, 4'd3}, '{1'b0, 4'd0,  8'h00, 4'd3},
    '{1'b1, 4'd4,  8'hFF, 4'd3}, '{1'b0, 4'd4,  8'h00, 4'd3},
    '{1'b1, 4'd5,  8'hFF, 4'd3}, '{1'b0, 4'd5,  8'h00, 4'd4},
    '{1'b1, 4'd8,  8'h47, 4'd3}, '{1'b0, 4'd8,  8'h47, 4'd3},
    '{1'b1, 4'd8,  8'h07, 4'd3}, '{1'b0, 4'd8,  8'h07, 4'd3}
  };

  function automatic logic [ADDR_W-1:0] ax(input int i);
    return ADDR_W'(i << STRIDE);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_chk(input int i, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd_a(ax(i), v);
    chk(tag, v, exp);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 cmd_err", {7'd0, cmd_err}, 8'h00);
    rd_chk(14, 8'h04, "R1 rev");
    rd_chk(8, 8'h07, "R1 cfg1");
    rd_chk(4, 8'h00, "R1 status");
    rd_chk(5, 8'h00, "R1 intr");

    // R2 undecoded index and stride
    wr_a(8'h6C, 8'h77);
    rd_chk(11, 8'h00, "R2 no alias");
    rd_a(8'h6C, v); chk("R2 undecoded read", v, 8'h00);
    wr_a(8'h2D, 8'h6B);
    rd_a(8'h2C, v); chk("R2 stride", v, 8'h6B);

    for (int k = 0; k < NV; k++) begin
      if (VTAB[k].wr) wr_a(ax(VTAB[k].ix), VTAB[k].val);
      else begin
        rd_a(ax(VTAB[k].ix), v);
        chk($sformatf("R%0d table[%0d]", VTAB[k].req, k), v, VTAB[k].val);
      end
    end

    // R6 pop with phase 0 returns zero, still raises
    wr_a(ax(2), 8'h11); wr_a(ax(2), 8'h22); wr_a(ax(2), 8'h33);
    rd_chk(2, 8'h00, "R6 phase0 data");
    chk("R6 pop irq", {7'd0, irq}, 8'h01);
    rd_chk(5, 8'h00, "R4 intr code");
    chk("R4 irq low", {7'd0, irq}, 8'h00);

    // R11 flush
    wr_a(ax(3), 8'h01);
    chk("R11 no irq", {7'd0, irq}, 8'h00);
    rd_chk(2, 8'h00, "R6 empty read");
    chk("R6 empty no irq", {7'd0, irq}, 8'h00);
    rd_chk(5, 8'h08, "R11 intr");
    rd_chk(7, 8'h00, "R11 flags");
    rd_chk(6, 8'h00, "R11 step");

    // R8 command-complete
    wr_a(ax(3), 8'h11);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    rd_chk(4, 8'h87, "R8 status");
    rd_chk(7, 8'h02, "R8 flags");
    rd_chk(5, 8'h08, "R8 intr");
    rd_chk(2, 8'h02, "R8 sense byte");
    rd_chk(2, 8'h00, "R8 msg byte");
    rd_chk(5, 8'h08, "R4 clear");
    rd_chk(2, 8'h00, "R6 empty after drain");
    chk("R6 empty no irq", {7'd0, irq}, 8'h00);

    // R5 fill, overrun, R7 order
    wr_a(ax(3), 8'h01);
    for (int k = 0; k < 15; k++) wr_a(ax(2), 8'hA0 + 8'(k));
    wr_a(ax(2), 8'hEE);
    rd_chk(4, 8'h47, "R5 gross error");
    for (int k = 0; k < 15; k++) rd_chk(2, 8'hA0 + 8'(k), "R7 order");
    rd_chk(2, 8'h00, "R5 dropped byte");
    rd_chk(4, 8'hC7, "R6 pend set");
    rd_chk(5, 8'h08, "R4 intr");
    rd_chk(4, 8'h07, "R4 errors cleared");
    wr_a(ax(2), 8'h5A); wr_a(ax(2), 8'h5B);
    rd_chk(2, 8'h5A, "R7 after reset ptr");
    rd_chk(2, 8'h5B, "R7 after reset ptr");
    rd_chk(5, 8'h08, "R4 intr");

    // R9 bus reset
    wr_a(ax(3), 8'h03);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    chk("R14 status mirror", {7'd0, irq}, 8'h01);
    rd_chk(5, 8'h80, "R9 code");
    chk("R14 irq low", {7'd0, irq}, 8'h00);
    wr_a(ax(8), 8'h47);
    wr_a(ax(3), 8'h03);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    rd_chk(5, 8'h80, "R9 masked code");
    wr_a(ax(8), 8'h07);

    // R10 enable selection
    wr_a(ax(3), 8'h03);
    wr_a(ax(3), 8'h44);
    chk("R10 irq kept", {7'd0, irq}, 8'h01);
    rd_chk(5, 8'h00, "R10 intr");

    // R13 unknown command, NOP
    wr_a(ax(3), 8'h00);
    chk("R13 nop", {7'd0, cmd_err}, 8'h00);
    wr_a(ax(3), 8'h7F);
    chk("R13 err", {7'd0, cmd_err}, 8'h01);
    rd_chk(5, 8'h00, "R13 intr kept");
    rd_chk(4, 8'h07, "R13 status kept");

    // R12 chip reset
    wr_a(ax(3), 8'h03);
    wr_a(ax(3), 8'h82);
    chk("R12 irq", {7'd0, irq}, 8'h00);
    rd_chk(14, 8'h04, "R12 rev");
    rd_chk(8, 8'h07, "R12 cfg1");
    rd_chk(4, 8'h00, "R12 status");
    rd_chk(11, 8'h00, "R12 cfg2");
    chk("R12 err kept", {7'd0, cmd_err}, 8'h01);

    done = 1'b1;
    summary();
  end
endmodule